// File: doc/BRIEF.md
# Watchdog and Clock-Loss Reset Generator

This block watches over a processor in two ways and asks for a system reset when either check fails. The first check is a watchdog counter that runs on the bus clock. Software must restart it before it reaches a period set by a 2-bit rate field. The second check is a clock monitor. It runs from a separate slow reference clock and looks for a bus clock that has stopped or slowed down. A control input turns the monitor on or off.

Both fault paths end in the reference-clock domain. A reset generator there stretches the request to a minimum length. It also latches a cause code, so that the reset sequencer outside this block can pick a separate vector for a watchdog fault and for a clock fault. Power-on reset is the only thing that clears the code.

A STOP-mode input marks the bus clock as halted. The watchdog freezes while STOP is high. If the monitor is enabled while STOP is high, the monitor treats the halted clock as a failure. All pins are plain control and status signals. No data streams through the block, so it has no valid/ready handshake.

Top module: `wdog_clkmon_rst`

## Requirements
- R1: While `rst_n` is low and after it is released, `rst_req` is 0 and `cause` is 2'b00.
- R2: Without service, the watchdog expires after BASE_CYCLES × 4^`rate_sel` bus-clock cycles. The multipliers are 1, 4, 16 and 64 for settings 0 to 3. Each expiry raises `rst_req` and sets the cause code 2'b01 (watchdog). The count then wraps and starts again.
- R3: A write of 8'h55 followed by a write of 8'hAA restarts the watchdog count. Idle cycles may come between the two writes, but no other write may.
- R4: A write of 8'hAA that does not directly follow a write of 8'h55 has no effect on the count. This includes the case where another value is written between 8'h55 and 8'hAA.
- R5: With `mon_en` set, a bus clock that stops makes `rst_req` rise once MON_LIMIT reference cycles pass with no bus-clock activity seen. The cause is 2'b10 (clock failure).
- R6: With `mon_en` clear, a stopped bus clock never raises `rst_req`.
- R7: While `stop_i` is high, the watchdog count is frozen. If `mon_en` is set at the same time, the monitor reports a clock failure.
- R8: `rst_req` stays high for as long as a clock failure persists. After the last fault event it stays high for HOLD_CYCLES more reference cycles.
- R9: The first cause recorded after power-on stays unchanged until the next `rst_n` assertion. If both faults arrive together, clock failure (2'b10) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; runs the watchdog |
| ref_clk | input | 1 | Independent slow reference clock; runs the monitor and the reset generator |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| rate_sel | input | 2 | Watchdog period select (×1, ×4, ×16, ×64) |
| mon_en | input | 1 | Clock monitor enable |
| stop_i | input | 1 | STOP mode: bus clock considered halted |
| wr_en | input | 1 | Write strobe to the service register |
| wr_data | input | 8 | Service register write value |
| rst_req | output | 1 | System reset request |
| cause | output | 2 | Latched cause: 00 none, 01 watchdog, 10 clock failure |

## Verification
A watchdog expiry occurs on the bus edge where the count completes its period. Its toggle then needs two reference edges to cross the synchronizer and a third to load the hold counter, so `rst_req` and `cause` change on the third reference rising edge after expiry. For a clock loss, the request rises on the reference edge that follows the gap counter reaching MON_LIMIT. The request falls HOLD_CYCLES reference edges after the last fault. The bench runs a behavioural model of both domains. It compares `rst_req` and `cause` with that model at every reference falling edge, which is half a cycle after any change, and adds window checks that confirm whether a reset happened in each scenario.

// File: rtl/wdcm_pkg.sv
`timescale 1ns/1ps
package wdcm_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_WDOG = 2'b01,
    CAUSE_CLK  = 2'b10
  } cause_e;

  localparam logic [7:0] SVC_KEY_FIRST  = 8'h55;
  localparam logic [7:0] SVC_KEY_SECOND = 8'hAA;
endpackage

// File: rtl/wdcm_sync.sv
`timescale 1ns/1ps
module wdcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= 1'b0;
        else        stg_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= 1'b0;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wdcm_wdog.sv
`timescale 1ns/1ps
module wdcm_wdog
  import wdcm_pkg::*;
#(
  parameter int BASE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       stop_i,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       wd_tgl_o,
  output logic       alive_tgl_o
);
  localparam int MAX_PERIOD = BASE_CYCLES * 64;
  localparam int CW = $clog2(MAX_PERIOD + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] period;
  logic          arm_q;
  logic          wd_tgl_q;
  logic          alive_q;
  logic          svc;

  always_comb begin
    period = CW'(BASE_CYCLES) << {rate_sel, 1'b0};
    svc    = wr_en && (wr_data == SVC_KEY_SECOND) && arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      arm_q    <= 1'b0;
      wd_tgl_q <= 1'b0;
      alive_q  <= 1'b0;
    end else begin
      if (!stop_i) alive_q <= ~alive_q;
      if (wr_en)   arm_q   <= (wr_data == SVC_KEY_FIRST);
      if (svc) begin
        cnt_q <= '0;
      end else if (!stop_i) begin
        if (cnt_q >= period - 1'b1) begin
          cnt_q    <= '0;
          wd_tgl_q <= ~wd_tgl_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign wd_tgl_o    = wd_tgl_q;
  assign alive_tgl_o = alive_q;

  // R2: an expiry always leaves the count at zero
  a_r2_expire_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wd_tgl_q) |-> cnt_q == '0);

  // R4: a lone second key keeps the count running
  a_r4_lone_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == SVC_KEY_SECOND && !arm_q && !stop_i && cnt_q < period - 1'b1)
    |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7: STOP freezes the count and the activity toggle
  a_r7_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !wr_en) |=> ($stable(cnt_q) && $stable(alive_q)));
endmodule

// File: rtl/wdcm_clkmon.sv
`timescale 1ns/1ps
module wdcm_clkmon #(
  parameter int MON_LIMIT = 4
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic alive_s,
  input  logic en_s,
  output logic fail_o
);
  localparam int GW = $clog2(MON_LIMIT + 1);

  logic [GW-1:0] gap_q;
  logic          prev_q;
  logic          seen;

  assign seen = alive_s ^ prev_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      prev_q <= alive_s;
      if (seen)                     gap_q <= '0;
      else if (gap_q < GW'(MON_LIMIT)) gap_q <= gap_q + 1'b1;
    end
  end

  assign fail_o = en_s && (gap_q >= GW'(MON_LIMIT));

  // R5: observed bus activity clears a pending failure
  a_r5_activity_clears: assert property (@(posedge ref_clk) disable iff (!rst_n)
    seen |=> !fail_o);

  // R5: the gap counter saturates at its limit
  a_r5_gap_saturates: assert property (@(posedge ref_clk) disable iff (!rst_n)
    gap_q <= GW'(MON_LIMIT));
endmodule

// File: rtl/wdcm_rstgen.sv
`timescale 1ns/1ps
module wdcm_rstgen
  import wdcm_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       fail_i,
  input  logic       wd_tgl_s,
  output logic       rst_req_o,
  output logic [1:0] cause_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] hold_q;
  logic          wd_prev_q;
  logic          wd_evt;
  cause_e        cause_q;

  assign wd_evt = wd_tgl_s ^ wd_prev_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      wd_prev_q <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else begin
      wd_prev_q <= wd_tgl_s;
      if (fail_i || wd_evt) hold_q <= HW'(HOLD_CYCLES);
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
      if (cause_q == CAUSE_NONE) begin
        if (fail_i)      cause_q <= CAUSE_CLK;
        else if (wd_evt) cause_q <= CAUSE_WDOG;
      end
    end
  end

  assign rst_req_o = (hold_q != '0);
  assign cause_o   = cause_q;

  // R9: a recorded cause never changes before power-on reset
  a_r9_cause_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cause_q != CAUSE_NONE |=> $stable(cause_q));

  // R9: clock failure wins when first recorded
  a_r9_clk_priority: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_i && cause_q == CAUSE_NONE) |=> cause_q == CAUSE_CLK);

  // R8: a persisting failure keeps the request high
  a_r8_fail_holds: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_i |=> rst_req_o);

  if (HOLD_CYCLES > 1) begin : g_hold_chk
    // R8: a request lasts more than one cycle
    a_r8_min_width: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(rst_req_o) |=> rst_req_o);
  end
endmodule

// File: rtl/wdog_clkmon_rst.sv
`timescale 1ns/1ps
module wdog_clkmon_rst #(
  parameter int BASE_CYCLES = 64,
  parameter int MON_LIMIT   = 4,
  parameter int HOLD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       mon_en,
  input  logic       stop_i,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       rst_req,
  output logic [1:0] cause
);
  logic wd_tgl, alive_tgl;
  logic wd_tgl_s, alive_s, en_s;
  logic mon_fail;

  wdcm_wdog #(.BASE_CYCLES(BASE_CYCLES)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .stop_i     (stop_i),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wd_tgl_o   (wd_tgl),
    .alive_tgl_o(alive_tgl)
  );

  wdcm_sync #(.STAGES(SYNC_STAGES)) u_sync_wd (
    .clk(ref_clk), .rst_n(rst_n), .d(wd_tgl), .q(wd_tgl_s)
  );

  wdcm_sync #(.STAGES(SYNC_STAGES)) u_sync_alive (
    .clk(ref_clk), .rst_n(rst_n), .d(alive_tgl), .q(alive_s)
  );

  wdcm_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
    .clk(ref_clk), .rst_n(rst_n), .d(mon_en), .q(en_s)
  );

  wdcm_clkmon #(.MON_LIMIT(MON_LIMIT)) u_mon (
    .ref_clk(ref_clk),
    .rst_n  (rst_n),
    .alive_s(alive_s),
    .en_s   (en_s),
    .fail_o (mon_fail)
  );

  wdcm_rstgen #(.HOLD_CYCLES(HOLD_CYCLES)) u_rst (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .fail_i   (mon_fail),
    .wd_tgl_s (wd_tgl_s),
    .rst_req_o(rst_req),
    .cause_o  (cause)
  );

  // R1: no request while power-on reset is applied
  a_r1_quiet_in_reset: assert property (@(posedge ref_clk)
    !rst_n |-> (!rst_req && cause == 2'b00));
endmodule

// File: tb/wdog_clkmon_rst_tb_top.sv
`timescale 1ns/1ps
module wdog_clkmon_rst_tb_top;
  localparam int BASE = 64;
  localparam int MLIM = 4;
  localparam int HOLD = 8;

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic clk_run = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic mon_en = 1'b0, stop_i = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_req;
  logic [1:0] cause;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit saw_rst = 1'b0;
  bit done = 1'b0;

  wdog_clkmon_rst #(.BASE_CYCLES(BASE), .MON_LIMIT(MLIM), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .mon_en(mon_en), .stop_i(stop_i), .wr_en(wr_en), .wr_data(wr_data),
    .rst_req(rst_req), .cause(cause)
  );

  // 250 MHz bus clock, gateable; edges on even ns
  always begin
    #2;
    if (clk_run) clk = ~clk;
  end
  // reference clock, 36 ns period; edges on odd ns
  initial begin
    #1;
    forever begin
      ref_clk = ~ref_clk;
      #18;
    end
  end

  // ---------------- behavioural reference model ----------------
  int m_cnt; bit m_arm, m_wdt, m_alive;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_arm = 0; m_wdt = 0; m_alive = 0;
    end else begin
      int lim;
      bit svc;
      lim = BASE * (4 ** rate_sel);
      svc = wr_en && wr_data == 8'hAA && m_arm;
      if (!stop_i) m_alive = !m_alive;
      if (wr_en) m_arm = (wr_data == 8'h55);
      if (svc) m_cnt = 0;
      else if (!stop_i) begin
        if (m_cnt >= lim - 1) begin m_cnt = 0; m_wdt = !m_wdt; end
        else m_cnt++;
      end
    end
  end

  bit a_q[$], w_q[$], e_q[$];
  bit a_prev, w_prev;
  int m_gap, m_hold, m_cause;
  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q = {1'b0, 1'b0}; w_q = {1'b0, 1'b0}; e_q = {1'b0, 1'b0};
      a_prev = 0; w_prev = 0; m_gap = 0; m_hold = 0; m_cause = 0;
    end else begin
      bit a_s, w_s, e_s, act, evt, fl;
      a_s = a_q[1]; w_s = w_q[1]; e_s = e_q[1];
      act = a_s != a_prev; evt = w_s != w_prev;
      fl = e_s && (m_gap >= MLIM);
      if (fl || evt) m_hold = HOLD; else if (m_hold > 0) m_hold--;
      if (m_cause == 0) begin
        if (fl) m_cause = 2; else if (evt) m_cause = 1;
      end
      if (act) m_gap = 0; else if (m_gap < MLIM) m_gap++;
      a_prev = a_s; w_prev = w_s;
      void'(a_q.pop_back()); a_q.push_front(m_alive);
      void'(w_q.pop_back()); w_q.push_front(m_wdt);
      void'(e_q.pop_back()); e_q.push_front(mon_en);
    end
  end

  // compare with the model half a reference cycle after each update
  always @(negedge ref_clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rst_req !== (m_hold != 0) || cause !== 2'(m_cause)) begin
        errors++;
        $display("FAIL %s model: rst_req=%0b cause=%0d expected rst_req=%0b cause=%0d",
                 tag, rst_req, cause, (m_hold != 0), m_cause);
      end
      if (rst_req) saw_rst = 1'b1;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ref_wait(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic por(logic [1:0] r, logic en);
    @(posedge ref_clk); #8;
    rst_n = 1'b0; rate_sel = r; mon_en = en; stop_i = 0; wr_en = 0; wr_data = 0;
    clk_run = 1'b1;
    @(posedge ref_clk); #8;
    rst_n = 1'b1;
    saw_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic halt_clk();
    @(negedge clk); clk_run = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    chk("R1 rst_req in reset", rst_req, 0);
    chk("R1 cause in reset", cause, 0);
    por(2'd0, 1'b0);
    idle(2);
    chk("R1 rst_req after release", rst_req, 0);
    chk("R1 cause after release", cause, 0);

    // R2: each rate multiplier
    tag = "R2";
    for (int r = 0; r < 4; r++) begin
      int lim;
      lim = BASE * (4 ** r);
      por(2'(r), 1'b0);
      idle(lim - 20);
      chk("R2 no early reset", saw_rst, 0);
      idle(80);
      chk("R2 reset after period", saw_rst, 1);
      chk("R2 cause watchdog", cause, 1);
    end

    // R3: correct service sequence keeps the reset away
    tag = "R3";
    por(2'd0, 1'b0);
    for (int k = 0; k < 10; k++) begin
      idle(30); wr(8'h55); idle(3); wr(8'hAA);
    end
    chk("R3 serviced no reset", saw_rst, 0);
    idle(100);
    chk("R3 reset once service stops", saw_rst, 1);

    // R4: wrong orders do not restart
    tag = "R4";
    por(2'd0, 1'b0);
    idle(20); wr(8'hAA); idle(5); wr(8'h55); wr(8'h12); wr(8'hAA);
    idle(60);
    chk("R4 timeout unaffected", saw_rst, 1);
    chk("R4 cause watchdog", cause, 1);

    // R5 and R8: clock loss with monitor enabled
    tag = "R5";
    por(2'd3, 1'b1);
    idle(20);
    halt_clk();
    ref_wait(12);
    chk("R5 rst_req on clock loss", rst_req, 1);
    chk("R5 cause clock", cause, 2);
    tag = "R8";
    ref_wait(10);
    chk("R8 held while clock absent", rst_req, 1);
    clk_run = 1'b1;
    ref_wait(4);
    chk("R8 held after clock returns", rst_req, 1);
    ref_wait(16);
    chk("R8 released after hold", rst_req, 0);

    // R6: monitor disabled ignores clock loss
    tag = "R6";
    por(2'd3, 1'b0);
    idle(10);
    halt_clk();
    ref_wait(30);
    chk("R6 no reset while stopped", saw_rst, 0);
    clk_run = 1'b1;
    idle(20);
    chk("R6 no reset after restart", saw_rst, 0);

    // R7: STOP with monitor enabled
    tag = "R7";
    por(2'd3, 1'b1);
    idle(20);
    stop_i = 1'b1;
    ref_wait(12);
    chk("R7 STOP with monitor resets", rst_req, 1);
    chk("R7 cause clock", cause, 2);
    @(negedge clk); stop_i = 1'b0;
    ref_wait(20);
    chk("R7 release after STOP ends", rst_req, 0);
    // R7: STOP freezes the watchdog
    por(2'd0, 1'b0);
    idle(30);
    stop_i = 1'b1;
    idle(300);
    chk("R7 frozen during STOP", saw_rst, 0);
    @(negedge clk); stop_i = 1'b0;
    idle(20);
    chk("R7 count resumes not restarted", saw_rst, 0);
    idle(60);
    chk("R7 timeout after resume", saw_rst, 1);

    // R9: cause sticky, cleared by power-on
    tag = "R9";
    por(2'd0, 1'b0);
    idle(120);
    chk("R9 first cause watchdog", cause, 1);
    @(negedge clk); mon_en = 1'b1;
    idle(10);
    halt_clk();
    ref_wait(12);
    chk("R9 clock loss still resets", rst_req, 1);
    chk("R9 cause unchanged", cause, 1);
    clk_run = 1'b1;
    ref_wait(20);
    por(2'd0, 1'b0);
    idle(2);
    chk("R9 cause cleared by power-on", cause, 0);

    finish_run();
  end
endmodule